// File: doc/BRIEF.md
# I/O MMU Queue Control Register File

This block is the software-visible register file that sits in front of the queue engines of an I/O memory management unit. It holds the setup for three circular queues kept in memory: a command queue, a fault queue and a page-request queue. For each queue it stores a base pointer, made of a page number and a log2 size, and a producer/consumer index. It also keeps a control/status word per queue, in which software asks for the queue to be turned on or off and then waits for an acknowledge. The base, size, index, enable and busy state go straight out to the queue engines. Command-queue and page-request-queue entries are 16 bytes each and fault-queue entries are 32 bytes. The engines work out addresses from that; this block only stores the fields.

The register file also holds a read-only capability word, a device-directory pointer, an interrupt-pending word that engines set and software clears by writing ones, and a vector-mapping word. The vector-mapping word assigns one of `NUM_VECS` interrupt vectors to each of four causes. Access is over a plain 32-bit read/write bus with combinational read data, and every 64-bit register is reached as two 32-bit halves. To bring a queue up, software programs the base, writes 0 to the index, sets the enable bit and then polls until the active bit reads 1.

Top module: `ioq_ctrl_regs`

## Requirements
- R1: After reset, every queue control word (byte addresses 0x2C, 0x3C, 0x4C for command, fault and page-request) reads 0, the pending word at 0x10 reads 0 and the vector word at 0x14 reads 0.
- R2: The capability low word at 0x00 reads 0x00000010, with the version in bits 7:0. Its high word at 0x04 reads 0. Writes change neither.
- R3: The vector word at 0x14 has four 4-bit fields: command [3:0], fault [7:4], performance-monitor [11:8] and page-request [15:12]. Only the low log2(NUM_VECS) bits of each field are stored, so with 4 vectors a write of 0xFFFF reads back 0x3333.
- R4: In a control word, bit 0 is enable, bit 1 is interrupt enable, bit 16 is active and bit 17 is busy. A write that changes enable relative to active raises busy for exactly ACK_LAT cycles (default 4). Active then takes the new enable value in the same cycle that busy clears.
- R5: Clearing enable on an active queue goes through the same ACK_LAT-cycle busy phase and ends with active at 0. The queue's qEnable output follows active.
- R6: A write to a control word while that queue is busy is ignored. Enable and interrupt enable keep their earlier values.
- R7: Queue q's base low word is at 0x20+16q and holds the log2 size in bits 4:0 and the low 22 page-number bits in bits 31:10. Its high word at 0x24+16q holds the upper page-number bits in bits 21:0. Software writes log2(entries)-1 into the size field. Outputs qBase and qLog2Sz carry the stored values.
- R8: Queue q's index word at 0x28+16q stores bits 15:0, reads 0 above them and drives qPtr.
- R9: Bits that no register implements, addresses that no register decodes (for example 0x0C, 0x18, 0x50) and unaligned addresses read 0 and ignore writes.
- R10: Pending bit i (0 command, 1 fault, 2 performance-monitor, 3 page-request) is set by a one-cycle pulse on irqSet[i] and cleared by writing 1 to bit i of 0x10. A set in the same cycle as a clear wins.
- R11: The device-directory word at 0x08 holds the mode in bits 3:0 and the page number in bits 31:10. It reads mode 0 (Off) after reset, and its busy bit 4 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Bus access strobe |
| regWrite | input | 1 | 1 for write, 0 for read |
| regAddr | input | ADDR_W | Byte address, word aligned |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| irqSet | input | 4 | One-cycle set pulses for the pending bits |
| qBase | output | 3 x PPN_W | Page number per queue |
| qLog2Sz | output | 3 x 5 | Log2 size field per queue |
| qPtr | output | 3 x PTR_W | Index per queue |
| qEnable | output | 3 | Active state per queue |
| qBusy | output | 3 | Handshake in progress per queue |
| qIrqEn | output | 3 | Interrupt enable per queue |
| vecMap | output | 4 x VEC_BITS | Vector number per cause |
| irqPending | output | 4 | Pending bits |
| dirMode | output | 4 | Device-directory mode |
| dirPpn | output | 22 | Device-directory page number |

## Verification
The vector mask is tested with 256 write patterns, and the base and index registers with 32 hashed patterns per queue. These runs tell correctly masked fields apart from bits that leak into unimplemented positions or land in the wrong half-word. The handshake is run on each queue and the busy cycles seen before active are counted against ACK_LAT, with a bounded poll. That check separates a correct latency from an early, late or missing acknowledge. Separate runs cover a write during busy, a disable, a set/clear race on the pending bits and all-ones writes to unmapped words.

// File: rtl/ioq_regs_pkg.sv
`timescale 1ns/1ps
package ioq_regs_pkg;
  localparam int NQ   = 3;
  localparam int QI_W = 2;
  localparam int NCAUSE = 4;
  localparam int CTRL_EN   = 0;
  localparam int CTRL_IE   = 1;
  localparam int CTRL_ACT  = 16;
  localparam int CTRL_BUSY = 17;
  localparam int PPN_LO_W  = 22;
  localparam logic [7:0] CAP_VERSION = 8'h10;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CAPLO, SEL_DIRLO, SEL_PEND, SEL_IVEC,
    SEL_BLO, SEL_BHI, SEL_PTR, SEL_CTRL
  } rdSel_e;

  typedef struct packed {
    logic          wrDir;
    logic          wrPend;
    logic          wrIvec;
    logic [NQ-1:0] wrBaseLo;
    logic [NQ-1:0] wrBaseHi;
    logic [NQ-1:0] wrPtr;
    rdSel_e        sel;
    logic [QI_W-1:0] qIdx;
  } strobe_t;
endpackage

// File: rtl/ioq_regs_ctrl.sv
`timescale 1ns/1ps
module ioq_regs_ctrl
  import ioq_regs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int ACK_LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        wdataLow,
  output strobe_t           st,
  output logic [NQ-1:0]     qEn,
  output logic [NQ-1:0]     qIe,
  output logic [NQ-1:0]     qAct,
  output logic [NQ-1:0]     qBusy
);
  localparam int CNT_W = (ACK_LAT < 2) ? 1 : $clog2(ACK_LAT);

  logic          wr;
  logic [NQ-1:0] wrCtrl;

  always_comb begin
    int wIdx;
    int qOff;
    st      = '0;
    st.sel  = SEL_NONE;
    wrCtrl  = '0;
    wr      = regValid & regWrite;
    wIdx    = int'(regAddr >> 2);
    qOff    = wIdx - 8;
    if (regAddr[1:0] == 2'b00) begin
      if (wIdx == 0) st.sel = SEL_CAPLO;
      else if (wIdx == 2) begin st.sel = SEL_DIRLO; st.wrDir = wr; end
      else if (wIdx == 4) begin st.sel = SEL_PEND;  st.wrPend = wr; end
      else if (wIdx == 5) begin st.sel = SEL_IVEC;  st.wrIvec = wr; end
      else if (wIdx >= 8 && wIdx < 8 + 4 * NQ) begin
        st.qIdx = QI_W'(qOff >> 2);
        case (qOff & 3)
          0: begin st.sel = SEL_BLO;  st.wrBaseLo[qOff >> 2] = wr; end
          1: begin st.sel = SEL_BHI;  st.wrBaseHi[qOff >> 2] = wr; end
          2: begin st.sel = SEL_PTR;  st.wrPtr[qOff >> 2]    = wr; end
          default: begin st.sel = SEL_CTRL; wrCtrl[qOff >> 2] = wr; end
        endcase
      end
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : gSeq
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        qEn[q]   <= 1'b0;
        qIe[q]   <= 1'b0;
        qAct[q]  <= 1'b0;
        qBusy[q] <= 1'b0;
        cnt      <= '0;
      end else if (qBusy[q]) begin
        if (cnt == '0) begin
          qAct[q]  <= qEn[q];
          qBusy[q] <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (wrCtrl[q]) begin
        qEn[q] <= wdataLow[CTRL_EN];
        qIe[q] <= wdataLow[CTRL_IE];
        if (wdataLow[CTRL_EN] != qAct[q]) begin
          qBusy[q] <= 1'b1;
          cnt      <= CNT_W'(ACK_LAT - 1);
        end
      end
    end
  end
endmodule

// File: rtl/ioq_regs_data.sv
`timescale 1ns/1ps
module ioq_regs_data
  import ioq_regs_pkg::*;
#(
  parameter int NUM_VECS = 4,
  parameter int PPN_W    = 44,
  parameter int PTR_W    = 16,
  localparam int VEC_BITS = (NUM_VECS < 2) ? 1 : $clog2(NUM_VECS),
  localparam int PPN_HI_W = PPN_W - PPN_LO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [31:0]       regWdata,
  input  logic [NCAUSE-1:0] irqSet,
  input  logic [NQ-1:0]     qEn,
  input  logic [NQ-1:0]     qIe,
  input  logic [NQ-1:0]     qAct,
  input  logic [NQ-1:0]     qBusy,
  output logic [31:0]       regRdata,
  output logic [NQ-1:0][PPN_W-1:0]  qBase,
  output logic [NQ-1:0][4:0]        qLog2Sz,
  output logic [NQ-1:0][PTR_W-1:0]  qPtr,
  output logic [NCAUSE-1:0][VEC_BITS-1:0] vecMap,
  output logic [NCAUSE-1:0] irqPending,
  output logic [3:0]        dirMode,
  output logic [PPN_LO_W-1:0] dirPpn
);
  for (genvar f = 0; f < NCAUSE; f++) begin : gVec
    always_ff @(posedge clk) begin
      if (!rstN) vecMap[f] <= '0;
      else if (st.wrIvec) vecMap[f] <= regWdata[f*4 +: VEC_BITS];
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : gQueue
    always_ff @(posedge clk) begin
      if (!rstN) begin
        qBase[q]   <= '0;
        qLog2Sz[q] <= '0;
        qPtr[q]    <= '0;
      end else begin
        if (st.wrBaseLo[q]) begin
          qBase[q][PPN_LO_W-1:0] <= regWdata[31:10];
          qLog2Sz[q]             <= regWdata[4:0];
        end
        if (st.wrBaseHi[q]) qBase[q][PPN_W-1:PPN_LO_W] <= regWdata[PPN_HI_W-1:0];
        if (st.wrPtr[q])    qPtr[q] <= regWdata[PTR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirMode    <= 4'd0;
      dirPpn     <= '0;
      irqPending <= '0;
    end else begin
      if (st.wrDir) begin
        dirMode <= regWdata[3:0];
        dirPpn  <= regWdata[31:10];
      end
      irqPending <= (irqPending & ~(st.wrPend ? regWdata[NCAUSE-1:0] : '0)) | irqSet;
    end
  end

  always_comb begin
    regRdata = '0;
    case (st.sel)
      SEL_CAPLO: regRdata = 32'(CAP_VERSION);
      SEL_DIRLO: regRdata = {dirPpn, 6'b0, dirMode};
      SEL_PEND:  regRdata = 32'(irqPending);
      SEL_IVEC:  for (int f = 0; f < NCAUSE; f++) regRdata[f*4 +: 4] = 4'(vecMap[f]);
      SEL_BLO:   regRdata = {qBase[st.qIdx][PPN_LO_W-1:0], 5'b0, qLog2Sz[st.qIdx]};
      SEL_BHI:   regRdata = 32'(qBase[st.qIdx][PPN_W-1:PPN_LO_W]);
      SEL_PTR:   regRdata = 32'(qPtr[st.qIdx]);
      SEL_CTRL: begin
        regRdata[CTRL_EN]   = qEn[st.qIdx];
        regRdata[CTRL_IE]   = qIe[st.qIdx];
        regRdata[CTRL_ACT]  = qAct[st.qIdx];
        regRdata[CTRL_BUSY] = qBusy[st.qIdx];
      end
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/ioq_ctrl_regs.sv
`timescale 1ns/1ps
module ioq_ctrl_regs
  import ioq_regs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int ACK_LAT  = 4,
  parameter int NUM_VECS = 4,
  parameter int PPN_W    = 44,
  parameter int PTR_W    = 16,
  localparam int VEC_BITS = (NUM_VECS < 2) ? 1 : $clog2(NUM_VECS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [3:0]        irqSet,
  output logic [2:0][PPN_W-1:0] qBase,
  output logic [2:0][4:0]       qLog2Sz,
  output logic [2:0][PTR_W-1:0] qPtr,
  output logic [2:0]        qEnable,
  output logic [2:0]        qBusy,
  output logic [2:0]        qIrqEn,
  output logic [3:0][VEC_BITS-1:0] vecMap,
  output logic [3:0]        irqPending,
  output logic [3:0]        dirMode,
  output logic [21:0]       dirPpn
);
  strobe_t       st;
  logic [NQ-1:0] qEn;

  ioq_regs_ctrl #(.ADDR_W(ADDR_W), .ACK_LAT(ACK_LAT)) uCtrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .wdataLow(regWdata[1:0]), .st(st),
    .qEn(qEn), .qIe(qIrqEn), .qAct(qEnable), .qBusy(qBusy)
  );

  ioq_regs_data #(.NUM_VECS(NUM_VECS), .PPN_W(PPN_W), .PTR_W(PTR_W)) uData (
    .clk(clk), .rstN(rstN), .st(st), .regWdata(regWdata), .irqSet(irqSet),
    .qEn(qEn), .qIe(qIrqEn), .qAct(qEnable), .qBusy(qBusy),
    .regRdata(regRdata), .qBase(qBase), .qLog2Sz(qLog2Sz), .qPtr(qPtr),
    .vecMap(vecMap), .irqPending(irqPending), .dirMode(dirMode), .dirPpn(dirPpn)
  );
endmodule

// File: rtl/ioq_ctrl_regs_chk.sv
`timescale 1ns/1ps
module ioq_ctrl_regs_chk #(
  parameter int ADDR_W   = 8,
  parameter int NUM_VECS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regValid,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regRdata,
  input logic [2:0]        qEnable,
  input logic [2:0]        qBusy
);
  localparam int VB = (NUM_VECS < 2) ? 1 : $clog2(NUM_VECS);
  localparam logic [31:0] FIELD = 32'((1 << VB) - 1);
  localparam logic [31:0] VMASK = FIELD | (FIELD << 4) | (FIELD << 8) | (FIELD << 12);

  // R2
  cap_version_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(0)) |-> (regRdata == 32'h10));

  // R3
  vec_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(8'h14)) |-> ((regRdata & ~VMASK) == 32'h0));

  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(8'h0C)) |-> (regRdata == 32'h0));

  for (genvar q = 0; q < 3; q++) begin : gQ
    // R4
    busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(qBusy[q]) |-> $past(regValid && regWrite && regAddr == ADDR_W'(32'h2C + 16 * q)));
    // R5
    active_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(qEnable[q]) |-> ($past(qBusy[q]) && !qBusy[q]));
  end
endmodule

bind ioq_ctrl_regs ioq_ctrl_regs_chk #(.ADDR_W(ADDR_W), .NUM_VECS(NUM_VECS)) uChk (
  .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
  .regAddr(regAddr), .regRdata(regRdata), .qEnable(qEnable), .qBusy(qBusy)
);

// File: tb/sim_ioq_ctrl_regs.sv
`timescale 1ns/1ps
module sim_ioq_ctrl_regs;
  localparam int LAT = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regValid = 1'b0, regWrite = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0] irqSet = '0;
  logic [2:0][43:0] qBase;
  logic [2:0][4:0] qLog2Sz;
  logic [2:0][15:0] qPtr;
  logic [2:0] qEnable, qBusy, qIrqEn;
  logic [3:0][1:0] vecMap;
  logic [3:0] irqPending, dirMode;
  logic [21:0] dirPpn;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ioq_ctrl_regs u0 (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqSet(irqSet),
    .qBase(qBase), .qLog2Sz(qLog2Sz), .qPtr(qPtr), .qEnable(qEnable),
    .qBusy(qBusy), .qIrqEn(qIrqEn), .vecMap(vecMap), .irqPending(irqPending),
    .dirMode(dirMode), .dirPpn(dirPpn)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
  endtask

  task automatic bringUp(input int q, input logic [31:0] val, input logic [31:0] expEnd, input string req);
    logic [31:0] v;
    int busyCnt = 0;
    logic seen = 1'b0;
    wr(8'(32'h2C + 16 * q), val);
    for (int n = 0; n < 40; n++) begin
      rd(8'(32'h2C + 16 * q), v);
      if (!v[17]) begin seen = 1'b1; break; end
      busyCnt++;
    end
    check({req, " settle within bound"}, 64'(seen), 64'd1);
    check({req, " busy cycles"}, 64'(busyCnt), 64'(LAT));
    check({req, " ctrl after"}, 64'(v), 64'(expEnd));
    check({req, " qEnable"}, 64'(qEnable[q]), 64'(expEnd[16]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, lo, hi;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    for (int q = 0; q < 3; q++) begin
      rd(8'(32'h2C + 16 * q), v); check("R1 ctrl reset", 64'(v), 64'd0);
    end
    rd(8'h10, v); check("R1 pending reset", 64'(v), 64'd0);
    rd(8'h14, v); check("R1 vec reset", 64'(v), 64'd0);
    // R11 directory word
    rd(8'h08, v); check("R11 dir reset", 64'(v), 64'd0);
    wr(8'h08, 32'hFFFF_FFF5);
    rd(8'h08, v); check("R11 dir mask busy bit", 64'(v), 64'hFFFF_FC05);
    check("R11 dir mode out", 64'(dirMode), 64'h5);
    // R2 capability
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R2 cap lo", 64'(v), 64'h10);
    rd(8'h04, v); check("R2 cap hi", 64'(v), 64'h0);
    // R3 vector mask sweep
    for (int i = 0; i < 256; i++) begin
      lo = 32'(i * 32'h0101) ^ 32'(i << 20);
      wr(8'h14, lo);
      rd(8'h14, v); check("R3 vec mask", 64'(v), 64'(lo & 32'h3333));
    end
    wr(8'h14, 32'hFFFF); rd(8'h14, v); check("R3 vec all ones", 64'(v), 64'h3333);
    // R7 R8 base and index sweep
    for (int q = 0; q < 3; q++) begin
      for (int k = 0; k < 32; k++) begin
        lo = 32'(k + 1) * 32'h9E37_79B1;
        hi = 32'(k + 7) * 32'h85EB_CA6B;
        wr(8'(32'h20 + 16 * q), lo);
        wr(8'(32'h24 + 16 * q), hi);
        wr(8'(32'h28 + 16 * q), hi ^ lo);
        rd(8'(32'h20 + 16 * q), v); check("R7 base lo", 64'(v), 64'(lo & 32'hFFFF_FC1F));
        rd(8'(32'h24 + 16 * q), v); check("R7 base hi", 64'(v), 64'(hi & 32'h003F_FFFF));
        check("R7 qBase", 64'(qBase[q]), {20'd0, hi[21:0], lo[31:10]});
        check("R7 qLog2Sz", 64'(qLog2Sz[q]), 64'(lo[4:0]));
        rd(8'(32'h28 + 16 * q), v); check("R8 index", 64'(v), 64'((hi ^ lo) & 32'hFFFF));
        check("R8 qPtr", 64'(qPtr[q]), 64'((hi ^ lo) & 32'hFFFF));
      end
      // bring-up order: base with log2 size of 4 entries minus 1, index 0
      wr(8'(32'h20 + 16 * q), 32'h0000_4001);
      wr(8'(32'h28 + 16 * q), 32'h0);
    end
    // R4 handshake on every queue
    for (int q = 0; q < 3; q++) bringUp(q, 32'h1, 32'h0001_0001, "R4 enable");
    // R5 disable
    bringUp(0, 32'h0, 32'h0, "R5 disable");
    // R6 write during busy is ignored
    wr(8'h3C, 32'h0);
    repeat (8) @(negedge clk);
    wr(8'h3C, 32'h2);
    repeat (8) @(negedge clk);
    rd(8'h3C, v); check("R6 fault ctrl before", 64'(v), 64'h2);
    wr(8'h4C, 32'h0);
    repeat (8) @(negedge clk);
    wr(8'h4C, 32'h1);
    wr(8'h4C, 32'h2);
    repeat (8) @(negedge clk);
    rd(8'h4C, v); check("R6 ignored while busy", 64'(v), 64'h0001_0001);
    check("R6 irq enable unchanged", 64'(qIrqEn[2]), 64'd0);
    // R9 unmapped and unaligned
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); wr(8'h52, 32'hFFFF_FFFF);
    rd(8'h0C, v); check("R9 unmapped 0C", 64'(v), 64'h0);
    rd(8'h18, v); check("R9 unmapped 18", 64'(v), 64'h0);
    rd(8'h50, v); check("R9 unmapped 50", 64'(v), 64'h0);
    rd(8'h2D, v); check("R9 unaligned", 64'(v), 64'h0);
    // R10 pending set and write-one-clear
    irqSet = 4'b1010; @(negedge clk); irqSet = 4'b0000;
    rd(8'h10, v); check("R10 pending set", 64'(v), 64'hA);
    wr(8'h10, 32'h8);
    rd(8'h10, v); check("R10 w1c", 64'(v), 64'h2);
    irqSet = 4'b0010; wr(8'h10, 32'hF); irqSet = 4'b0000;
    rd(8'h10, v); check("R10 set wins", 64'(v), 64'h2);
    check("R10 irqPending out", 64'(irqPending), 64'h2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule